// File: doc/BRIEF.md
# Interrupt and Wake-up Controller

This block collects the interrupt sources of a small microcontroller core. The sources are a timer overflow pulse, any change on an 8-bit input port, two external interrupt pins that share one edge-select setting, and a change of the comparator output. Every source has a sticky flag that hardware sets and software clears. Every source also has an enable bit. One global enable, driven by the core's enable, disable and return-from-interrupt instructions, gates the request to the core. Flags are recorded whatever the enables say.

Port and comparator changes are found by comparing the synchronised live value with a snapshot. The snapshot is taken each time software reads the port or the comparator status. While the core sleeps, a port or comparator change can raise a wake-up signal if its wake-enable bit is set. The core then takes the interrupt only when the global enable is on. Vector fetch and context saving belong to the core.

Top module: `irq_wake_top`

## Requirements
- R1: After reset the flag, enable and configuration registers read 0, the global enable is 0, and `irqReq` and `wakeUp` are 0.
- R2: A one-cycle `tmrOvf` pulse sets flag bit 0 at the next clock edge.
- R3: External pins pass through two synchronising flops. A flag sets on the third edge after the pin changes. Configuration bit 0 at 0 selects rising edges and at 1 selects falling edges, for both pins. Pin 0 sets flag bit 2 and pin 1 sets flag bit 3.
- R4: An external pin sets no flag while its select bit is 0. Configuration bit 1 selects pin 0 and bit 2 selects pin 1.
- R5: Flag bit 1 sets while the synchronised port differs from the snapshot taken on the last `rdPort` pulse. A clear does not hold while the difference remains.
- R6: Flag bit 4 sets while the synchronised comparator output differs from the snapshot taken on the last `rdCmp` pulse.
- R7: A `wrFlag` write clears the flags whose data bit is 0 and leaves the flags whose data bit is 1. A hardware set in the same cycle wins over the clear.
- R8: Flags set whatever the enable bits and the global enable are.
- R9: `irqReq` is high exactly when the global enable is 1 and at least one flag has its enable bit (same bit position) set.
- R10: `insEni` or `insReti` sets the global enable and `insDisi` or `irqTake` clears it; a clear wins over a set in the same cycle. No register write changes it.
- R11: `wakeUp` is high only while `sleeping` is high. It rises when configuration bit 3 is set together with port flag 1, or bit 4 together with comparator flag 4. The other flags do not wake the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tmrOvf | input | 1 | Timer overflow pulse (synchronous) |
| portPins | input | 8 | Input port pins (asynchronous) |
| extPin0 | input | 1 | External interrupt pin 0 (asynchronous) |
| extPin1 | input | 1 | External interrupt pin 1 (asynchronous) |
| cmpOut | input | 1 | Comparator output (asynchronous) |
| wrFlag | input | 1 | Write strobe, flag register (clear-on-zero) |
| wrEn | input | 1 | Write strobe, enable register |
| wrCfg | input | 1 | Write strobe, configuration register |
| wrData | input | 8 | Write data |
| rdPort | input | 1 | Core read of the port: takes the port snapshot |
| rdCmp | input | 1 | Core read of the comparator status: takes the comparator snapshot |
| insEni | input | 1 | Enable-interrupts instruction |
| insDisi | input | 1 | Disable-interrupts instruction |
| insReti | input | 1 | Return-from-interrupt instruction |
| irqTake | input | 1 | Core takes an interrupt |
| sleeping | input | 1 | Core is in sleep |
| irqReq | output | 1 | Interrupt request to the core |
| wakeUp | output | 1 | Wake-up request |
| flagsOut | output | 8 | Flag register read value |
| enOut | output | 8 | Enable register read value |
| cfgOut | output | 8 | Configuration register read value |
| gieOut | output | 1 | Global enable read value |

## Verification
Two cases can fall in the same cycle. In the first, a software clear of a flag meets a new hardware set. The bench holds `tmrOvf` high in the same cycle as a clearing `wrFlag` and expects the flag to stay set. In the second, a set and a clear of the global enable arrive together. The bench pulses `insEni` with `insDisi` in one cycle and expects the global enable to be 0. The port change case is a related conflict: software clears the flag while the live port still differs from the snapshot. The flag must come straight back until `rdPort` refreshes the snapshot.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  localparam int NSRC     = 5;
  localparam int SRC_TMR  = 0;
  localparam int SRC_PORT = 1;
  localparam int SRC_EXT0 = 2;
  localparam int SRC_EXT1 = 3;
  localparam int SRC_CMP  = 4;

  localparam int CFG_W     = 5;
  localparam int CFG_FALL  = 0;
  localparam int CFG_SEL0  = 1;
  localparam int CFG_SEL1  = 2;
  localparam int CFG_PWAKE = 3;
  localparam int CFG_CWAKE = 4;

  typedef struct packed {
    logic flagWr;
    logic enWr;
    logic cfgWr;
    logic latchPort;
    logic latchCmp;
  } dpStrobe_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN)
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrFlag,
  input  logic      wrEn,
  input  logic      wrCfg,
  input  logic      rdPort,
  input  logic      rdCmp,
  input  logic      insEni,
  input  logic      insDisi,
  input  logic      insReti,
  input  logic      irqTake,
  input  logic      sleeping,
  input  logic      pending,
  input  logic      wakeHit,
  output dpStrobe_t strobe,
  output logic      gie,
  output logic      irqReq,
  output logic      wakeUp
);
  logic gieSet, gieClr;

  always_comb begin
    strobe.flagWr    = wrFlag;
    strobe.enWr      = wrEn;
    strobe.cfgWr     = wrCfg;
    strobe.latchPort = rdPort;
    strobe.latchCmp  = rdCmp;
  end

  assign gieSet = insEni | insReti;
  assign gieClr = insDisi | irqTake;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)       gie <= 1'b0;
    else if (gieClr) gie <= 1'b0;
    else if (gieSet) gie <= 1'b1;

  assign irqReq = gie & pending;
  assign wakeUp = sleeping & wakeHit;
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_wake_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tmrOvf,
  input  logic [PORT_W-1:0] portPins,
  input  logic              extPin0,
  input  logic              extPin1,
  input  logic              cmpOut,
  output logic [NSRC-1:0]   flags,
  output logic [NSRC-1:0]   enables,
  output logic [CFG_W-1:0]  cfg,
  output logic              pending,
  output logic              wakeHit
);
  localparam int RAW_W = PORT_W + 3;

  logic [RAW_W-1:0]  rawIn, syncIn;
  logic [PORT_W-1:0] portSync, portSnap;
  logic [1:0]        extSync, extPrev, extHit;
  logic              cmpSync, cmpSnap;
  logic [NSRC-1:0]   hwSet, keepMask;

  assign rawIn = {cmpOut, extPin1, extPin0, portPins};

  irq_sync #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncIn)
  );

  assign portSync = syncIn[PORT_W-1:0];
  assign extSync  = syncIn[PORT_W+1:PORT_W];
  assign cmpSync  = syncIn[PORT_W+2];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      extPrev  <= '0;
      portSnap <= '0;
      cmpSnap  <= 1'b0;
    end else begin
      extPrev <= extSync;
      if (strobe.latchPort) portSnap <= portSync;
      if (strobe.latchCmp)  cmpSnap  <= cmpSync;
    end

  for (genvar e = 0; e < 2; e++) begin : g_ext
    logic rise, fall, sel;
    assign rise = extSync[e] & ~extPrev[e];
    assign fall = ~extSync[e] & extPrev[e];
    assign sel  = cfg[CFG_SEL0 + e];
    assign extHit[e] = sel & (cfg[CFG_FALL] ? fall : rise);
  end

  always_comb begin
    hwSet           = '0;
    hwSet[SRC_TMR]  = tmrOvf;
    hwSet[SRC_PORT] = (portSync != portSnap);
    hwSet[SRC_EXT0] = extHit[0];
    hwSet[SRC_EXT1] = extHit[1];
    hwSet[SRC_CMP]  = (cmpSync != cmpSnap);
    keepMask = strobe.flagWr ? wrData[NSRC-1:0] : '1;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      flags   <= '0;
      enables <= '0;
      cfg     <= '0;
    end else begin
      flags <= (flags & keepMask) | hwSet;
      if (strobe.enWr)  enables <= wrData[NSRC-1:0];
      if (strobe.cfgWr) cfg     <= wrData[CFG_W-1:0];
    end

  assign pending = |(flags & enables);
  assign wakeHit = (cfg[CFG_PWAKE] & flags[SRC_PORT]) |
                   (cfg[CFG_CWAKE] & flags[SRC_CMP]);
endmodule

// File: rtl/irq_wake_top.sv
module irq_wake_top
  import irq_wake_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrOvf,
  input  logic [PORT_W-1:0] portPins,
  input  logic              extPin0,
  input  logic              extPin1,
  input  logic              cmpOut,
  input  logic              wrFlag,
  input  logic              wrEn,
  input  logic              wrCfg,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdPort,
  input  logic              rdCmp,
  input  logic              insEni,
  input  logic              insDisi,
  input  logic              insReti,
  input  logic              irqTake,
  input  logic              sleeping,
  output logic              irqReq,
  output logic              wakeUp,
  output logic [DATA_W-1:0] flagsOut,
  output logic [DATA_W-1:0] enOut,
  output logic [DATA_W-1:0] cfgOut,
  output logic              gieOut
);
  dpStrobe_t        strobe;
  logic [NSRC-1:0]  flags, enables;
  logic [CFG_W-1:0] cfg;
  logic             pending, wakeHit;

  irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrFlag(wrFlag), .wrEn(wrEn), .wrCfg(wrCfg),
    .rdPort(rdPort), .rdCmp(rdCmp), .insEni(insEni), .insDisi(insDisi),
    .insReti(insReti), .irqTake(irqTake), .sleeping(sleeping),
    .pending(pending), .wakeHit(wakeHit), .strobe(strobe), .gie(gieOut),
    .irqReq(irqReq), .wakeUp(wakeUp)
  );

  irq_datapath #(.PORT_W(PORT_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .tmrOvf(tmrOvf),
    .portPins(portPins), .extPin0(extPin0), .extPin1(extPin1), .cmpOut(cmpOut),
    .flags(flags), .enables(enables), .cfg(cfg), .pending(pending),
    .wakeHit(wakeHit)
  );

  assign flagsOut = DATA_W'(flags);
  assign enOut    = DATA_W'(enables);
  assign cfgOut   = DATA_W'(cfg);
endmodule

// File: rtl/irq_wake_chk.sv
module irq_wake_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tmrOvf,
  input logic              wrFlag,
  input logic              insEni,
  input logic              insDisi,
  input logic              insReti,
  input logic              irqTake,
  input logic              sleeping,
  input logic              irqReq,
  input logic              wakeUp,
  input logic [DATA_W-1:0] flagsOut,
  input logic [DATA_W-1:0] enOut,
  input logic              gieOut
);
  // R2
  tmr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvf |=> flagsOut[0]);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrFlag |=> ((flagsOut & $past(flagsOut)) == $past(flagsOut)));

  // R9
  req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gieOut |-> !irqReq);

  // R9
  req_needs_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((flagsOut & enOut) != '0));

  // R10
  gie_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (insDisi || irqTake) |=> !gieOut);

  // R10
  gie_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((insEni || insReti) && !insDisi && !irqTake) |=> gieOut);

  // R11
  wake_only_asleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sleeping |-> !wakeUp);
endmodule

bind irq_wake_top irq_wake_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .tmrOvf(tmrOvf), .wrFlag(wrFlag),
  .insEni(insEni), .insDisi(insDisi), .insReti(insReti), .irqTake(irqTake),
  .sleeping(sleeping), .irqReq(irqReq), .wakeUp(wakeUp),
  .flagsOut(flagsOut), .enOut(enOut), .gieOut(gieOut)
);

// File: tb/irq_wake_top_tb.sv
`timescale 1ns/1ps
module irq_wake_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tmrOvf = 0, extPin0 = 0, extPin1 = 0, cmpOut = 0;
  logic [7:0] portPins = '0;
  logic       wrFlag = 0, wrEn = 0, wrCfg = 0;
  logic [7:0] wrData = '0;
  logic       rdPort = 0, rdCmp = 0;
  logic       insEni = 0, insDisi = 0, insReti = 0, irqTake = 0, sleeping = 0;
  logic       irqReq, wakeUp, gieOut;
  logic [7:0] flagsOut, enOut, cfgOut;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_wake_top u_dut (
    .clk(clk), .rstN(rstN), .tmrOvf(tmrOvf), .portPins(portPins),
    .extPin0(extPin0), .extPin1(extPin1), .cmpOut(cmpOut), .wrFlag(wrFlag),
    .wrEn(wrEn), .wrCfg(wrCfg), .wrData(wrData), .rdPort(rdPort), .rdCmp(rdCmp),
    .insEni(insEni), .insDisi(insDisi), .insReti(insReti), .irqTake(irqTake),
    .sleeping(sleeping), .irqReq(irqReq), .wakeUp(wakeUp), .flagsOut(flagsOut),
    .enOut(enOut), .cfgOut(cfgOut), .gieOut(gieOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 0 flags, 1 enables, 2 config
  task automatic wrReg(input int which, input logic [7:0] d);
    wrData = d;
    wrFlag = (which == 0); wrEn = (which == 1); wrCfg = (which == 2);
    step(1);
    wrFlag = 0; wrEn = 0; wrCfg = 0;
  endtask

  task automatic t_reset;
    check("R1 flags", flagsOut, 0);
    check("R1 enables", enOut, 0);
    check("R1 config", cfgOut, 0);
    check("R1 gie", gieOut, 0);
    check("R1 irqReq", irqReq, 0);
    check("R1 wakeUp", wakeUp, 0);
  endtask

  task automatic t_timer;
    tmrOvf = 1; step(1); tmrOvf = 0;
    check("R2 timer flag", flagsOut, 8'h01);
    check("R8 no gie/en needed, irqReq", irqReq, 0);
    wrReg(0, 8'hFF);
    check("R7 write one keeps", flagsOut, 8'h01);
    wrReg(0, 8'h1E);
    check("R7 write zero clears", flagsOut, 8'h00);
    tmrOvf = 1; wrFlag = 1; wrData = 8'h00; step(1);
    tmrOvf = 0; wrFlag = 0;
    check("R7 set wins over clear", flagsOut, 8'h01);
    wrReg(0, 8'h00);
  endtask

  task automatic t_ext;
    extPin0 = 1; step(4);
    check("R4 ext0 masked", flagsOut, 8'h00);
    extPin0 = 0; step(4);
    wrReg(2, 8'h06);
    extPin0 = 1; step(2);
    check("R3 two-flop latency", flagsOut, 8'h00);
    step(1);
    check("R3 ext0 rising", flagsOut, 8'h04);
    wrReg(0, 8'h00);
    extPin0 = 0; step(4);
    check("R3 ext0 falling ignored", flagsOut, 8'h00);
    extPin1 = 1; step(3);
    check("R3 ext1 rising", flagsOut, 8'h08);
    wrReg(0, 8'h00);
    wrReg(2, 8'h07);
    extPin1 = 0; step(3);
    check("R3 ext1 falling", flagsOut, 8'h08);
    wrReg(0, 8'h00);
    extPin0 = 1; step(4);
    check("R3 ext0 rising ignored", flagsOut, 8'h00);
    extPin0 = 0; step(3);
    check("R3 ext0 falling", flagsOut, 8'h04);
    wrReg(0, 8'h00);
    wrReg(2, 8'h00);
  endtask

  task automatic t_port;
    portPins = 8'h5A; step(3);
    check("R5 port change", flagsOut, 8'h02);
    wrReg(0, 8'h00);
    check("R5 mismatch resets flag", flagsOut, 8'h02);
    rdPort = 1; step(1); rdPort = 0;
    wrReg(0, 8'h00); step(2);
    check("R5 after snapshot", flagsOut, 8'h00);
    portPins = 8'h5B; step(3);
    check("R5 single bit change", flagsOut, 8'h02);
    rdPort = 1; step(1); rdPort = 0;
    wrReg(0, 8'h00);
  endtask

  task automatic t_cmp;
    cmpOut = 1; step(3);
    check("R6 comparator rise", flagsOut, 8'h10);
    rdCmp = 1; step(1); rdCmp = 0;
    wrReg(0, 8'h00); step(2);
    check("R6 after snapshot", flagsOut, 8'h00);
    cmpOut = 0; step(3);
    check("R6 comparator fall", flagsOut, 8'h10);
    rdCmp = 1; step(1); rdCmp = 0;
    wrReg(0, 8'h00);
  endtask

  task automatic t_gie;
    wrReg(1, 8'h01);
    tmrOvf = 1; step(1); tmrOvf = 0;
    check("R9 no request without gie", irqReq, 0);
    insEni = 1; step(1); insEni = 0;
    check("R10 eni sets", gieOut, 1);
    check("R9 request", irqReq, 1);
    irqTake = 1; step(1); irqTake = 0;
    check("R10 take clears", gieOut, 0);
    check("R9 request drops", irqReq, 0);
    insReti = 1; step(1); insReti = 0;
    check("R10 reti sets", gieOut, 1);
    wrReg(1, 8'h02);
    check("R9 enable mismatch", irqReq, 0);
    wrReg(2, 8'hFF); wrReg(1, 8'hFF); wrReg(0, 8'h00);
    check("R10 writes leave gie", gieOut, 1);
    insEni = 1; insDisi = 1; step(1); insEni = 0; insDisi = 0;
    check("R10 clear wins", gieOut, 0);
    wrReg(1, 8'h00); wrReg(2, 8'h00);
  endtask

  task automatic t_wake;
    sleeping = 1;
    portPins = 8'hA5; step(3);
    check("R11 port flag set", flagsOut, 8'h02);
    check("R11 no wake without enable", wakeUp, 0);
    rdPort = 1; step(1); rdPort = 0; wrReg(0, 8'h00);
    wrReg(2, 8'h08);
    portPins = 8'h00; step(3);
    check("R11 port wake", wakeUp, 1);
    sleeping = 0; #1;
    check("R11 awake no wake", wakeUp, 0);
    sleeping = 1;
    rdPort = 1; step(1); rdPort = 0; wrReg(0, 8'h00);
    tmrOvf = 1; step(1); tmrOvf = 0;
    check("R11 timer no wake", wakeUp, 0);
    wrReg(0, 8'h00);
    wrReg(2, 8'h10);
    cmpOut = 1; step(3);
    check("R11 comparator wake", wakeUp, 1);
    sleeping = 0;
  endtask

  initial begin
    step(2); rstN = 1; step(1);
    t_reset; t_timer; t_ext; t_port; t_cmp; t_gie; t_wake;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule